// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block decides who drives a shared external memory bus. There are three contenders: a foreign master, a DMA engine and the CPU. The foreign master asks through an active-low hold request and is answered on an active-low acknowledge. The DMA engine and the CPU each raise a request level and own the bus while their grant is high. A bus sequencer pulses `cycle_done` when the access in flight completes. Ownership changes only at that boundary, or when the bus is idle. When several contenders are pending, the order is foreign master, then DMA, then CPU.

While the foreign master holds the bus, the block turns off the output enables of the address, data, strobe, chip-select and byte-high-enable pin groups. It freezes the general-purpose port outputs at the value they had when the hold began, and it raises a stop signal for the watchdog timer. The hold request is asynchronous to the bus clock, so it passes through a synchronizer before the arbiter sees it.

Top module: `bus_hold_arbiter`

## Requirements
- R1: During and right after reset, no owner is selected: both grants are low, `hlda_n` is high, every bit of `pin_oe` is high, `wdt_stop` is low and `port_q` is zero.
- R2: `hold_n` is synchronized through two flops. From an idle bus, a low level first sampled at rising edge k drives `hlda_n` low after edge k+2.
- R3: While the DMA or CPU grant is high and `cycle_done` is low, the grant stays high and `hlda_n` stays high, even if a hold request is pending.
- R4: `hlda_n` stays low as long as the synchronized hold request stays active. A high level first sampled at edge k drives `hlda_n` high after edge k+2.
- R5: At an arbitration point (idle bus, or `cycle_done` high while the DMA or CPU grant is high), the winner is the hold request first, then `dma_req`, then `cpu_req`.
- R6: When DMA and CPU request together with no hold pending, DMA is granted. The CPU request stays pending and is granted at the first arbitration point at which `dma_req` is low.
- R7: At most one of `dma_gnt`, `cpu_gnt` and the acknowledge (`hlda_n` low) is active in any cycle.
- R8: `pin_oe` bits are 0 address, 1 data, 2 strobe, 3 chip select, 4 byte-high-enable. All of them are low exactly when `hlda_n` is low, and all of them are high otherwise.
- R9: `port_q` follows `port_d` one cycle later, except during hold. During hold it keeps the value captured at the edge that entered hold, and it resumes following one cycle after `hlda_n` rises.
- R10: `wdt_stop` is high in exactly the cycles in which `hlda_n` is low.
- R11: In the cycle after hold ends (`hlda_n` rises), no grant is active. The highest-priority pending requester is granted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_n | input | 1 | Asynchronous active-low hold request from a foreign master |
| dma_req | input | 1 | DMA bus request level |
| cpu_req | input | 1 | CPU bus request level |
| cycle_done | input | 1 | Pulse from the bus sequencer: current access completes this cycle |
| port_d | input | PORT_W | Next values for the general-purpose port outputs |
| hlda_n | output | 1 | Active-low hold acknowledge |
| dma_gnt | output | 1 | DMA owns the bus |
| cpu_gnt | output | 1 | CPU owns the bus |
| pin_oe | output | 5 | Output enables of the bus pin groups, high = driven |
| port_q | output | PORT_W | General-purpose port outputs, frozen during hold |
| wdt_stop | output | 1 | Watchdog stop, high during hold |

## Verification
The assertions check the cycle-by-cycle invariants on every cycle: a single owner, pin enables tied to the acknowledge, the watchdog stop tied to the acknowledge, grants kept until `cycle_done`, port outputs stable during hold, and an empty cycle after release. Other behaviours need the bench's scenarios. These are the exact synchronizer latency, the priority order at each arbitration point, a CPU request surviving a DMA win, and the port value actually captured at hold entry.

// File: rtl/bha_pkg.sv
package bha_pkg;

  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_CPU  = 2'd1,
    OWN_DMA  = 2'd2,
    OWN_HOLD = 2'd3
  } bus_own_e;

  localparam int PIN_GROUPS = 5;
  localparam int PIN_ADDR   = 0;
  localparam int PIN_DATA   = 1;
  localparam int PIN_STROBE = 2;
  localparam int PIN_CS     = 3;
  localparam int PIN_BHE    = 4;

  // Fixed priority: foreign master, DMA, CPU.
  function automatic bus_own_e pick_owner(input logic hold_act,
                                          input logic dma_act,
                                          input logic cpu_act);
    if (hold_act)     return OWN_HOLD;
    else if (dma_act) return OWN_DMA;
    else if (cpu_act) return OWN_CPU;
    else              return OWN_IDLE;
  endfunction

  // A new owner may be chosen when the bus is idle or an access ends.
  function automatic logic at_boundary(input bus_own_e cur,
                                       input logic done);
    return (cur == OWN_IDLE) ||
           (((cur == OWN_CPU) || (cur == OWN_DMA)) && done);
  endfunction

endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain[g] <= RESET_VAL;
        end else if (g == 0) begin
          chain[g] <= async_in;
        end else begin
          chain[g] <= chain[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/bha_arb.sv
module bha_arb
  import bha_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hold_act,
  input  logic     dma_req,
  input  logic     cpu_req,
  input  logic     cycle_done,
  output bus_own_e owner,
  output logic     arb_point,
  output logic     hold_enter,
  output logic     hold_leave
);

  bus_own_e owner_q, owner_d;

  assign arb_point = at_boundary(owner_q, cycle_done);

  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      OWN_IDLE, OWN_CPU, OWN_DMA: begin
        if (arb_point) owner_d = pick_owner(hold_act, dma_req, cpu_req);
      end
      OWN_HOLD: begin
        if (!hold_act) owner_d = OWN_IDLE;
      end
      default: owner_d = OWN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_IDLE;
    else        owner_q <= owner_d;
  end

  assign owner      = owner_q;
  assign hold_enter = (owner_q != OWN_HOLD) && (owner_d == OWN_HOLD);
  assign hold_leave = (owner_q == OWN_HOLD) && (owner_d != OWN_HOLD);

endmodule

// File: rtl/bha_pinctl.sv
module bha_pinctl
  import bha_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  bus_own_e              owner,
  input  logic [PORT_W-1:0]     port_d,
  output logic [PIN_GROUPS-1:0] pin_oe,
  output logic [PORT_W-1:0]     port_q,
  output logic                  wdt_stop,
  output logic                  hlda_n
);

  logic in_hold;
  assign in_hold = (owner == OWN_HOLD);

  genvar g;
  generate
    for (g = 0; g < PIN_GROUPS; g++) begin : g_oe
      assign pin_oe[g] = ~in_hold;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        port_q <= '0;
    else if (!in_hold) port_q <= port_d;
  end

  assign wdt_stop = in_hold;
  assign hlda_n   = ~in_hold;

endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
  import bha_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hold_n,
  input  logic                  dma_req,
  input  logic                  cpu_req,
  input  logic                  cycle_done,
  input  logic [PORT_W-1:0]     port_d,
  output logic                  hlda_n,
  output logic                  dma_gnt,
  output logic                  cpu_gnt,
  output logic [PIN_GROUPS-1:0] pin_oe,
  output logic [PORT_W-1:0]     port_q,
  output logic                  wdt_stop
);

  logic     hold_n_sync;
  logic     hold_act;
  bus_own_e owner;
  logic     arb_point;
  logic     hold_enter;
  logic     hold_leave;

  bha_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (hold_n),
    .sync_out (hold_n_sync)
  );

  assign hold_act = ~hold_n_sync;

  bha_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_act   (hold_act),
    .dma_req    (dma_req),
    .cpu_req    (cpu_req),
    .cycle_done (cycle_done),
    .owner      (owner),
    .arb_point  (arb_point),
    .hold_enter (hold_enter),
    .hold_leave (hold_leave)
  );

  bha_pinctl #(.PORT_W(PORT_W)) u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .owner    (owner),
    .port_d   (port_d),
    .pin_oe   (pin_oe),
    .port_q   (port_q),
    .wdt_stop (wdt_stop),
    .hlda_n   (hlda_n)
  );

  assign dma_gnt = (owner == OWN_DMA);
  assign cpu_gnt = (owner == OWN_CPU);

endmodule

// File: rtl/bus_hold_arbiter_chk.sv
module bus_hold_arbiter_chk #(
  parameter int PORT_W = 8,
  parameter int GROUPS = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cycle_done,
  input logic              hlda_n,
  input logic              dma_gnt,
  input logic              cpu_gnt,
  input logic [GROUPS-1:0] pin_oe,
  input logic [PORT_W-1:0] port_q,
  input logic              wdt_stop,
  input logic              hold_enter
);

  a_r7_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dma_gnt, cpu_gnt, ~hlda_n}));

  a_r8_pins_float: assert property (@(posedge clk) disable iff (!rst_n)
    (!hlda_n) == (pin_oe == '0) && (hlda_n == (pin_oe == '1)));

  a_r10_wdt_stop: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_stop == !hlda_n);

  a_r3_dma_held: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_gnt && !cycle_done) |=> dma_gnt);

  a_r3_cpu_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt && !cycle_done) |=> cpu_gnt);

  a_r9_port_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!hlda_n && $past(!hlda_n)) |-> $stable(port_q));

  a_r11_gap_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda_n) |-> (!dma_gnt && !cpu_gnt));

  a_r2_enter_from_release: assert property (@(posedge clk) disable iff (!rst_n)
    hold_enter |=> !hlda_n);

endmodule

bind bus_hold_arbiter bus_hold_arbiter_chk #(
  .PORT_W (PORT_W),
  .GROUPS (bha_pkg::PIN_GROUPS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cycle_done (cycle_done),
  .hlda_n     (hlda_n),
  .dma_gnt    (dma_gnt),
  .cpu_gnt    (cpu_gnt),
  .pin_oe     (pin_oe),
  .port_q     (port_q),
  .wdt_stop   (wdt_stop),
  .hold_enter (hold_enter)
);

// File: tb/bus_hold_arbiter_bench.sv
module bus_hold_arbiter_bench;

  localparam int PW = 8;
  localparam int NV = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hold_n = 1'b1;
  logic          dma_req = 1'b0;
  logic          cpu_req = 1'b0;
  logic          cycle_done = 1'b0;
  logic [PW-1:0] port_d = '0;
  logic          hlda_n, dma_gnt, cpu_gnt, wdt_stop;
  logic [4:0]    pin_oe;
  logic [PW-1:0] port_q;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  bus_hold_arbiter #(.PORT_W(PW)) u_bus_hold_arbiter (
    .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .dma_req(dma_req),
    .cpu_req(cpu_req), .cycle_done(cycle_done), .port_d(port_d),
    .hlda_n(hlda_n), .dma_gnt(dma_gnt), .cpu_gnt(cpu_gnt),
    .pin_oe(pin_oe), .port_q(port_q), .wdt_stop(wdt_stop)
  );

  // {hold_n, dma_req, cpu_req, cycle_done, exp_hlda_n, exp_dma, exp_cpu}
  localparam logic [6:0] VEC [NV] = '{
    7'b1000_100,  // R1 idle stays idle
    7'b1010_101,  // R5 cpu alone wins
    7'b1110_101,  // R3 cpu kept without done
    7'b1111_110,  // R6 dma wins over cpu
    7'b1011_101,  // R6 cpu served after dma drops
    7'b0010_101,  // R2 sync stage 1
    7'b0010_101,  // R2 sync stage 2
    7'b0010_101,  // R3 hold waits for done
    7'b0111_000,  // R5 hold wins at boundary
    7'b0110_000,  // R4 hold kept
    7'b1110_000,  // R4 release sync 1
    7'b1110_000,  // R4 release sync 2
    7'b1110_100,  // R11 empty cycle after hold
    7'b1110_110,  // R11 dma granted next
    7'b1101_110,  // R5 dma keeps priority
    7'b1001_100   // R5 nobody pending
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic h, input logic d, input logic c,
                      input logic x, input logic [PW-1:0] p);
    hold_n = h; dma_req = d; cpu_req = c; cycle_done = x; port_d = p;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_side(input string tag);
    // R8 and R10: pin enables and watchdog stop follow the acknowledge
    check({tag, " R8"}, {27'd0, pin_oe}, hlda_n ? 32'h1f : 32'h0);
    check({tag, " R10"}, {31'd0, wdt_stop}, {31'd0, ~hlda_n});
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    join_none

    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 hlda", {31'd0, hlda_n}, 32'd1);
    check("R1 grants", {30'd0, dma_gnt, cpu_gnt}, 32'd0);
    check("R1 oe", {27'd0, pin_oe}, 32'h1f);
    check("R1 port", {24'd0, port_q}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], 8'h00);
      check($sformatf("vec%0d R5", i), {29'd0, hlda_n, dma_gnt, cpu_gnt},
            {29'd0, VEC[i][2:0]});
      check_side($sformatf("vec%0d", i));
    end

    // R9: port capture at hold entry, frozen during hold
    step(0, 0, 0, 0, 8'h11);
    step(0, 0, 0, 0, 8'h22);
    step(0, 0, 0, 0, 8'h33);
    check("R2 hold entry", {31'd0, hlda_n}, 32'd0);
    check("R9 captured", {24'd0, port_q}, 32'h33);
    step(0, 0, 0, 0, 8'h44);
    step(0, 0, 0, 0, 8'h55);
    check("R9 frozen", {24'd0, port_q}, 32'h33);
    check_side("hold");
    step(1, 0, 0, 0, 8'h66);
    step(1, 0, 0, 0, 8'h77);
    check("R4 still held", {31'd0, hlda_n}, 32'd0);
    step(1, 0, 0, 0, 8'h88);
    check("R4 released", {31'd0, hlda_n}, 32'd1);
    check("R9 frozen at release", {24'd0, port_q}, 32'h33);
    step(1, 0, 0, 0, 8'h99);
    check("R9 follows again", {24'd0, port_q}, 32'h99);

    // R1 reset in the middle of a hold
    step(0, 0, 0, 0, 8'h5a);
    step(0, 0, 0, 0, 8'h5a);
    step(0, 0, 0, 0, 8'h5a);
    check("R4 held again", {31'd0, hlda_n}, 32'd0);
    rst_n = 1'b0;
    #1;
    check("R1 async reset hlda", {31'd0, hlda_n}, 32'd1);
    check("R1 async reset port", {24'd0, port_q}, 32'd0);
    hold_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {29'd0, hlda_n, dma_gnt, cpu_gnt}, 32'd4);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule